// File: doc/BRIEF.md
# Gray-Coded Counter Crossing Between Two Clock Domains

This block moves a slowly advancing multi-bit count, for instance a pulse or sweep index, from a source clock domain into an unrelated destination clock domain. On the source side the binary value is turned into its reflected Gray code and held in a register. Only that Gray word crosses the boundary. A short chain of destination-clocked flip-flops absorbs metastability, and the word at the end of the chain is decoded back to binary and registered. A one-cycle flag marks every destination cycle in which the decoded value moved.

Each side has its own active-low reset. The caller synchronizes each reset to its own clock beforehand. Inside the block each reset is sampled synchronously on its own clock, and it clears only the registers of that side. The destination can therefore be reset and brought back while the source keeps counting, and the two resets may be released in either order and at unrelated times.

Top module: `gray_xing_top`

## Requirements
- R1: The value width (`DATA_W`, default 6, minimum 2) and the number of destination synchronizer stages (`SYNC_STAGES`, default 3, minimum 2) are parameters.
- R2: A low `srcRstN`, sampled on a `srcClk` edge, sets the source Gray register to zero even when `srcValid` is high. The destination output then settles to 0. The destination reset does not touch this register.
- R3: On a `srcClk` edge with `srcValid` high, the source register takes the Gray code of `srcData`. With `srcValid` low it keeps its value, so changes on `srcData` never reach `dstData`.
- R4: A low `dstRstN`, sampled on a `dstClk` edge, gives `dstData` = 0 and `dstValid` = 0 after that edge. This holds while the source is running and counting.
- R5: The value crosses only as a Gray code. When the source advances by +1 (mod 2^DATA_W) no faster than once per two destination periods, each new `dstData` value is either the previous value or its successor mod 2^DATA_W. Every source value is seen at the output.
- R6: `dstValid` is high for exactly those destination cycles in which `dstData` differs from its value in the previous cycle. It is low during destination reset and in the first cycle after reset is released.
- R7: When a source update is held stable, it appears on `dstData` within SYNC_STAGES+2 destination clock periods.
- R8: After the destination reset is released while the source is out of reset, `dstData` settles to the current source value and tracks it afterwards.
- R9: Once both resets have been applied, `dstData` and `dstValid` carry no X or Z. This holds whichever reset is released first and however far apart the two releases are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| srcClk | input | 1 | Source domain clock |
| srcRstN | input | 1 | Source reset, active low, synchronous to srcClk |
| srcData | input | DATA_W | Binary value to be carried across |
| srcValid | input | 1 | Qualifies srcData; the register loads only when high |
| dstClk | input | 1 | Destination domain clock |
| dstRstN | input | 1 | Destination reset, active low, synchronous to dstClk |
| dstData | output | DATA_W | Decoded binary value in the destination domain |
| dstValid | output | 1 | One-cycle flag that dstData has just changed |

## Verification
The bench builds the block with `DATA_W` = 4 and `SYNC_STAGES` = 3. A 4-bit count wraps every sixteen steps, so a sweep of a few dozen increments passes through every code and crosses the wrap boundary several times. Each destination cycle is checked against the successor rule and the change flag. The same short configuration keeps the latency bound at five cycles, which is small enough to measure on every probe. It also leaves room for several reset scenarios: destination-only reset, source-only reset and releases in both orders, each run while the source keeps counting.

// File: rtl/gray_xing_pkg.sv
package gray_xing_pkg;

  // Strobes sent from destination control to destination datapath
  typedef struct packed {
    logic clear;       // destination reset sampled low
    logic shiftEn;     // advance the synchronizer chain
    logic flagChange;  // synchronized word moved this cycle
  } dstStrobe_t;

endpackage

// File: rtl/gray_xing_src.sv
module gray_xing_src #(
  parameter int DATA_W = 6
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic [DATA_W-1:0] srcData,
  input  logic              srcValid,
  output logic [DATA_W-1:0] srcGray
);

  logic [DATA_W-1:0] grayNext;

  // Reflected binary: each bit XOR its upper neighbour
  always_comb begin
    grayNext = srcData ^ (srcData >> 1);
  end

  always_ff @(posedge srcClk) begin
    if (!srcRstN) begin
      srcGray <= '0;
    end else if (srcValid) begin
      srcGray <= grayNext;
    end
  end

  // R3
  hold_when_idle_chk: assert property (@(posedge srcClk) disable iff (!srcRstN)
    !srcValid |=> $stable(srcGray));

  // R2
  src_clear_chk: assert property (@(posedge srcClk) disable iff (!srcRstN)
    $past(!srcRstN) |-> (srcGray == '0));

endmodule

// File: rtl/gray_xing_dst_ctrl.sv
module gray_xing_dst_ctrl
  import gray_xing_pkg::*;
#(
  parameter int DATA_W = 6
) (
  input  logic              dstClk,
  input  logic              dstRstN,
  input  logic [DATA_W-1:0] lastGray,
  output dstStrobe_t        strobe
);

  logic [DATA_W-1:0] prevGray;

  always_ff @(posedge dstClk) begin
    if (!dstRstN) begin
      prevGray <= '0;
    end else begin
      prevGray <= lastGray;
    end
  end

  always_comb begin
    strobe.clear      = !dstRstN;
    strobe.shiftEn    = dstRstN;
    strobe.flagChange = dstRstN && (lastGray != prevGray);
  end

endmodule

// File: rtl/gray_xing_dst_path.sv
module gray_xing_dst_path
  import gray_xing_pkg::*;
#(
  parameter int DATA_W      = 6,
  parameter int SYNC_STAGES = 3
) (
  input  logic              dstClk,
  input  logic              dstRstN,
  input  logic [DATA_W-1:0] srcGray,
  input  dstStrobe_t        strobe,
  output logic [DATA_W-1:0] lastGray,
  output logic [DATA_W-1:0] dstData,
  output logic              dstValid
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [DATA_W-1:0] syncChain [SYNC_STAGES];

  function automatic logic [DATA_W-1:0] grayToBin(input logic [DATA_W-1:0] g);
    logic [DATA_W-1:0] b;
    b[DATA_W-1] = g[DATA_W-1];
    for (int i = DATA_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gStage
      if (s == 0) begin : gHead
        always_ff @(posedge dstClk) begin
          if (strobe.clear) begin
            syncChain[0] <= '0;
          end else if (strobe.shiftEn) begin
            syncChain[0] <= srcGray;
          end
        end
      end else begin : gBody
        always_ff @(posedge dstClk) begin
          if (strobe.clear) begin
            syncChain[s] <= '0;
          end else if (strobe.shiftEn) begin
            syncChain[s] <= syncChain[s-1];
          end
        end
      end
    end
  endgenerate

  assign lastGray = syncChain[LAST];

  always_ff @(posedge dstClk) begin
    if (strobe.clear) begin
      dstData  <= '0;
      dstValid <= 1'b0;
    end else begin
      dstData  <= grayToBin(lastGray);
      dstValid <= strobe.flagChange;
    end
  end

  // R4
  dst_clear_chk: assert property (@(posedge dstClk) disable iff (!dstRstN)
    $past(!dstRstN) |-> (dstData == '0 && !dstValid));

  // R6
  valid_marks_change_chk: assert property (@(posedge dstClk) disable iff (!dstRstN)
    dstValid |-> (dstData != $past(dstData)));

  // R6
  quiet_holds_chk: assert property (@(posedge dstClk) disable iff (!dstRstN)
    !dstValid |-> $stable(dstData));

endmodule

// File: rtl/gray_xing_top.sv
module gray_xing_top
  import gray_xing_pkg::*;
#(
  parameter int DATA_W      = 6,
  parameter int SYNC_STAGES = 3
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic [DATA_W-1:0] srcData,
  input  logic              srcValid,
  input  logic              dstClk,
  input  logic              dstRstN,
  output logic [DATA_W-1:0] dstData,
  output logic              dstValid
);

  logic [DATA_W-1:0] srcGray;
  logic [DATA_W-1:0] lastGray;
  dstStrobe_t        strobe;

  // R1: widths and stage count come only from the parameters
  initial begin
    if (DATA_W < 2 || SYNC_STAGES < 2) begin
      $display("gray_xing_top: DATA_W and SYNC_STAGES must be at least 2");
    end
  end

  gray_xing_src #(.DATA_W(DATA_W)) uSrc (
    .srcClk  (srcClk),
    .srcRstN (srcRstN),
    .srcData (srcData),
    .srcValid(srcValid),
    .srcGray (srcGray)
  );

  gray_xing_dst_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .dstClk  (dstClk),
    .dstRstN (dstRstN),
    .lastGray(lastGray),
    .strobe  (strobe)
  );

  gray_xing_dst_path #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uPath (
    .dstClk  (dstClk),
    .dstRstN (dstRstN),
    .srcGray (srcGray),
    .strobe  (strobe),
    .lastGray(lastGray),
    .dstData (dstData),
    .dstValid(dstValid)
  );

endmodule

// File: tb/gray_xing_top_test.sv
`timescale 1ns/1ps
module gray_xing_top_test;

  localparam int W    = 4;
  localparam int STG  = 3;
  localparam int MODV = 1 << W;

  logic         srcClk = 1'b0;
  logic         dstClk = 1'b0;
  logic         srcRstN = 1'b0;
  logic         dstRstN = 1'b0;
  logic [W-1:0] srcData = '0;
  logic         srcValid = 1'b0;
  logic [W-1:0] dstData;
  logic         dstValid;

  int  testCount = 0;
  int  failCount = 0;
  bit  monOn = 1'b0;
  bit  done = 1'b0;
  int  prevOut = 0;
  int  validSeen = 0;
  int  srcCnt = 0;

  always #4.0 dstClk = ~dstClk;
  initial begin
    #1.3;
    forever #3.3 srcClk = ~srcClk;
  end

  gray_xing_top #(.DATA_W(W), .SYNC_STAGES(STG)) uut (
    .srcClk(srcClk), .srcRstN(srcRstN), .srcData(srcData), .srcValid(srcValid),
    .dstClk(dstClk), .dstRstN(dstRstN), .dstData(dstData), .dstValid(dstValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  // Per-cycle monitor for R5 and R6
  always @(negedge dstClk) begin
    if (monOn) begin
      check(dstValid === (int'(dstData) != prevOut), "R6 valid flag", int'(dstValid),
            int'(int'(dstData) != prevOut));
      check(int'(dstData) == prevOut || int'(dstData) == (prevOut + 1) % MODV,
            "R5 successor", int'(dstData), (prevOut + 1) % MODV);
      if (dstValid) validSeen++;
      prevOut = int'(dstData);
    end
  end

  task automatic srcStep(input int n);
    for (int k = 0; k < n; k++) begin
      srcCnt = (srcCnt + 1) % MODV;
      @(negedge srcClk);
      srcData  = W'(srcCnt);
      srcValid = 1'b1;
      @(negedge srcClk);
      srcValid = 1'b0;
      @(negedge srcClk);
    end
  endtask

  task automatic dstWait(input int n);
    repeat (n) @(negedge dstClk);
  endtask

  task automatic noXCheck(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge dstClk);
      check(!$isunknown({dstData, dstValid}), req, 0, 0);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog actual=1 expected=0");
      summary();
    end
  end

  initial begin
    int lat;
    // Reset state (R4)
    dstWait(5);
    check(dstData == '0, "R4 reset data", int'(dstData), 0);
    check(dstValid == 1'b0, "R4 reset valid", int'(dstValid), 0);

    // Staggered release, source first (R9)
    @(negedge srcClk) srcRstN = 1'b1;
    dstWait(3);
    dstRstN = 1'b1;
    noXCheck(8, "R9 no X after src-first release");
    check(dstData == '0, "R2 idle source reads zero", int'(dstData), 0);

    // Full sweep through several wraps (R1, R5, R6)
    prevOut = int'(dstData);
    validSeen = 0;
    monOn = 1'b1;
    srcStep(40);
    dstWait(10);
    check(int'(dstData) == srcCnt, "R5 sweep end value", int'(dstData), srcCnt);
    check(validSeen == 40, "R6 one pulse per step", validSeen, 40);
    check($bits(dstData) == W, "R1 width parameter", $bits(dstData), W);

    // Hold while srcValid is low (R3)
    for (int v = 0; v < MODV; v++) begin
      @(negedge srcClk) srcData = W'(v);
    end
    dstWait(10);
    check(int'(dstData) == srcCnt, "R3 idle input ignored", int'(dstData), srcCnt);

    // Latency probes (R7)
    for (int p = 0; p < 6; p++) begin
      srcCnt = (srcCnt + 1) % MODV;
      @(negedge srcClk);
      srcData  = W'(srcCnt);
      srcValid = 1'b1;
      @(negedge srcClk);
      srcValid = 1'b0;
      lat = 0;
      while (int'(dstData) != srcCnt && lat < 20) begin
        @(negedge dstClk);
        lat++;
      end
      check(lat <= STG + 2, "R7 latency", lat, STG + 2);
      dstWait(p % 3);
    end

    // Destination reset while source keeps counting (R4, R8)
    monOn = 1'b0;
    @(negedge dstClk) dstRstN = 1'b0;
    srcStep(5);
    @(negedge dstClk);
    check(dstData == '0, "R4 dst reset clears data", int'(dstData), 0);
    check(dstValid == 1'b0, "R4 dst reset clears valid", int'(dstValid), 0);
    dstRstN = 1'b1;
    srcStep(3);
    dstWait(8);
    check(int'(dstData) == srcCnt, "R8 track after dst reset", int'(dstData), srcCnt);
    prevOut = int'(dstData);
    monOn = 1'b1;
    srcStep(7);
    dstWait(8);
    check(int'(dstData) == srcCnt, "R8 follows after recovery", int'(dstData), srcCnt);

    // Source reset overrides srcValid and clears to zero (R2)
    monOn = 1'b0;
    @(negedge srcClk);
    srcRstN  = 1'b0;
    srcData  = W'(9);
    srcValid = 1'b1;
    repeat (3) @(negedge srcClk);
    srcValid = 1'b0;
    srcRstN  = 1'b1;
    dstWait(10);
    check(dstData == '0, "R2 source reset clears", int'(dstData), 0);
    srcCnt = 0;
    srcStep(5);
    dstWait(8);
    check(int'(dstData) == 5, "R2 count resumes", int'(dstData), 5);

    // Both in reset, destination released first (R9)
    @(negedge srcClk) srcRstN = 1'b0;
    @(negedge dstClk) dstRstN = 1'b0;
    dstWait(4);
    dstRstN = 1'b1;
    noXCheck(6, "R9 no X after dst-first release");
    check(dstData == '0, "R9 zero while source held", int'(dstData), 0);
    @(negedge srcClk) srcRstN = 1'b1;
    srcCnt = 0;
    prevOut = 0;
    monOn = 1'b1;
    srcStep(20);
    dstWait(10);
    check(int'(dstData) == srcCnt, "R9 tracking after late src release", int'(dstData), srcCnt);
    monOn = 1'b0;

    done = 1'b1;
    summary();
  end

endmodule